// File: doc/BRIEF.md
# Cyclic Flag-Offset Register Port

This block holds the two thresholds that a FIFO's partial-level flags compare against: the almost-empty offset n and the almost-full offset m. Each offset is kept as two 9-bit halves, so four registers exist in all. No address bus reaches them. The FIFO's own data input and data output carry the register contents, and a single active-low load strobe moves those buses from FIFO traffic to register traffic.

Writes are taken on the write clock and reads on the read clock. Each domain has a hidden two-bit selector that moves one step on every register access. The order is empty-low, empty-high, full-low, full-high, and then it wraps back to empty-low. The selector keeps its position while the load strobe is high. Software can therefore program a subset of the registers, return to normal traffic, and later continue with the next register in the sequence.

The block also decodes the enables into FIFO write and read requests for the storage logic. It presents n and m, each truncated to the pointer width, to the flag logic.

Top module: `flag_ofs_port`

## Requirements
- R1: With `load_n` low and `wr_en_n` low, successive rising `wr_clk` edges store `din` into empty-low, empty-high, full-low and full-high, in that order.
- R2: The fifth such write edge stores into empty-low again, and the cycle repeats.
- R3: While `load_n` is high, the write selector keeps its position. The first offset write after `load_n` falls again goes to the register after the last one written.
- R4: A `wr_clk` and `rd_clk` edge with `rst` high sets each low half to 7 and each high half to 0, so `empty_ofs` = `full_ofs` = 7. It also clears `rd_data` to 0 and returns both selectors to empty-low.
- R5: With `load_n`, `rd_en1_n` and `rd_en2_n` all low, each rising `rd_clk` edge loads `rd_data` with the register the read selector points to. The read selector then steps through the same cyclic order as writes, independently of the write selector.
- R6: A `rd_clk` edge with either read enable high, or with `load_n` high, leaves `rd_data` and the read selector unchanged.
- R7: A `wr_clk` edge with `wr_en_n` high, or with `load_n` high, changes no offset register and leaves the write selector where it is.
- R8: `fifo_wr_req` is high exactly when `load_n` is high and `wr_en_n` is low. `fifo_rd_req` is high exactly when `load_n` is high and both read enables are low. Neither is high while `load_n` is low.
- R9: `empty_ofs` is {empty-high, empty-low}, and `full_ofs` is {full-high, full-low}; each 18-bit value is truncated to `DEPTH_LOG2` bits (15 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| load_n | input | 1 | Active-low strobe routing the buses to the offset registers |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en1_n | input | 1 | First active-low read enable |
| rd_en2_n | input | 1 | Second active-low read enable |
| din | input | DATA_W | Shared write data bus |
| rd_data | output | DATA_W | Offset register read data |
| fifo_wr_req | output | 1 | Decoded FIFO write request |
| fifo_rd_req | output | 1 | Decoded FIFO read request |
| empty_ofs | output | DEPTH_LOG2 | Combined almost-empty offset n |
| full_ofs | output | DEPTH_LOG2 | Combined almost-full offset m |

## Verification
A write enable can be low in the same cycle that the load strobe is low, so a FIFO write and an offset write compete for one edge. The bench drives both low together. It then checks that no FIFO write request appears and that the offset register the selector points to takes the data. The bench also drives a FIFO write with the strobe high between two partial programming bursts. This shows that the write selector neither moves nor disturbs an offset when the strobe is released.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

    localparam int unsigned SLOT_N     = 4;
    localparam int unsigned LO_DEFAULT = 7;

    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;

    // Fixed cyclic access order shared by both selectors.
    function automatic slot_e slot_next(slot_e s);
        case (s)
            SLOT_E_LO: return SLOT_E_HI;
            SLOT_E_HI: return SLOT_F_LO;
            SLOT_F_LO: return SLOT_F_HI;
            default:   return SLOT_E_LO;
        endcase
    endfunction

endpackage

// File: rtl/fop_wr_bank.sv
module fop_wr_bank
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 9
) (
    input  logic                          wr_clk,
    input  logic                          rst,
    input  logic                          load_n,
    input  logic                          wr_en_n,
    input  logic [DATA_W-1:0]             din,
    output logic [SLOT_N-1:0][DATA_W-1:0] bank_o,
    output logic                          fifo_wr_req
);

    logic  ld_wr;
    slot_e wsel_q;

    assign ld_wr       = ~load_n & ~wr_en_n;
    assign fifo_wr_req =  load_n & ~wr_en_n;

    always_ff @(posedge wr_clk) begin
        if (rst) begin
            wsel_q <= SLOT_E_LO;
        end else if (ld_wr) begin
            wsel_q <= slot_next(wsel_q);
        end
    end

    // One register per slot; even slots are low halves with a nonzero default.
    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        localparam logic [DATA_W-1:0] RST_V = (g % 2 == 0) ? DATA_W'(LO_DEFAULT) : '0;
        logic [DATA_W-1:0] q;

        always_ff @(posedge wr_clk) begin
            if (rst) begin
                q <= RST_V;
            end else if (ld_wr && (wsel_q == slot_e'(g))) begin
                q <= din;
            end
        end

        assign bank_o[g] = q;
    end

endmodule

// File: rtl/fop_rd_path.sv
module fop_rd_path
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 9
) (
    input  logic                          rd_clk,
    input  logic                          rst,
    input  logic                          load_n,
    input  logic                          rd_en1_n,
    input  logic                          rd_en2_n,
    input  logic [SLOT_N-1:0][DATA_W-1:0] bank_i,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          fifo_rd_req
);

    logic              rd_both;
    logic              ld_rd;
    slot_e             rsel_q;
    logic [DATA_W-1:0] rd_q;

    assign rd_both     = ~rd_en1_n & ~rd_en2_n;
    assign ld_rd       = ~load_n & rd_both;
    assign fifo_rd_req =  load_n & rd_both;

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rsel_q <= SLOT_E_LO;
            rd_q   <= '0;
        end else if (ld_rd) begin
            rd_q   <= bank_i[rsel_q];
            rsel_q <= slot_next(rsel_q);
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/fop_join.sv
module fop_join
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DATA_W     = 9,
    parameter int unsigned DEPTH_LOG2 = 15
) (
    input  logic [SLOT_N-1:0][DATA_W-1:0] bank_i,
    output logic [DEPTH_LOG2-1:0]         empty_ofs,
    output logic [DEPTH_LOG2-1:0]         full_ofs
);

    localparam int unsigned CAT_W = 2 * DATA_W;

    logic [CAT_W-1:0] e_cat;
    logic [CAT_W-1:0] f_cat;

    assign e_cat = {bank_i[SLOT_E_HI], bank_i[SLOT_E_LO]};
    assign f_cat = {bank_i[SLOT_F_HI], bank_i[SLOT_F_LO]};

    // Size cast truncates or zero-extends to the pointer width.
    assign empty_ofs = DEPTH_LOG2'(e_cat);
    assign full_ofs  = DEPTH_LOG2'(f_cat);

endmodule

// File: rtl/flag_ofs_port.sv
module flag_ofs_port
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DATA_W     = 9,
    parameter int unsigned DEPTH_LOG2 = 15
) (
    input  logic                  wr_clk,
    input  logic                  rd_clk,
    input  logic                  rst,
    input  logic                  load_n,
    input  logic                  wr_en_n,
    input  logic                  rd_en1_n,
    input  logic                  rd_en2_n,
    input  logic [DATA_W-1:0]     din,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  fifo_wr_req,
    output logic                  fifo_rd_req,
    output logic [DEPTH_LOG2-1:0] empty_ofs,
    output logic [DEPTH_LOG2-1:0] full_ofs
);

    logic [SLOT_N-1:0][DATA_W-1:0] bank;

    fop_wr_bank #(.DATA_W(DATA_W)) u_wr (
        .wr_clk      (wr_clk),
        .rst         (rst),
        .load_n      (load_n),
        .wr_en_n     (wr_en_n),
        .din         (din),
        .bank_o      (bank),
        .fifo_wr_req (fifo_wr_req)
    );

    // Bank is quasi-static in the read domain: offset writes and reads never overlap.
    fop_rd_path #(.DATA_W(DATA_W)) u_rd (
        .rd_clk      (rd_clk),
        .rst         (rst),
        .load_n      (load_n),
        .rd_en1_n    (rd_en1_n),
        .rd_en2_n    (rd_en2_n),
        .bank_i      (bank),
        .rd_data     (rd_data),
        .fifo_rd_req (fifo_rd_req)
    );

    fop_join #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_join (
        .bank_i    (bank),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

endmodule

// File: rtl/flag_ofs_port_chk.sv
module flag_ofs_port_chk #(
    parameter int unsigned DATA_W     = 9,
    parameter int unsigned DEPTH_LOG2 = 15
) (
    input logic                  wr_clk,
    input logic                  rd_clk,
    input logic                  rst,
    input logic                  load_n,
    input logic                  wr_en_n,
    input logic                  rd_en1_n,
    input logic                  rd_en2_n,
    input logic [DATA_W-1:0]     din,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  fifo_wr_req,
    input logic                  fifo_rd_req,
    input logic [DEPTH_LOG2-1:0] empty_ofs,
    input logic [DEPTH_LOG2-1:0] full_ofs
);

    // Independent count of offset writes, used as a reference slot position.
    logic [1:0] wcnt;
    always_ff @(posedge wr_clk) begin
        if (rst) wcnt <= 2'd0;
        else if (!load_n && !wr_en_n) wcnt <= wcnt + 2'd1;
    end

    assert_elo_load_R1: assert property (@(posedge wr_clk) disable iff (rst)
        (!load_n && !wr_en_n && wcnt == 2'd0) |=> empty_ofs[DATA_W-1:0] == $past(din));

    assert_flo_load_R1: assert property (@(posedge wr_clk) disable iff (rst)
        (!load_n && !wr_en_n && wcnt == 2'd2) |=> full_ofs[DATA_W-1:0] == $past(din));

    assert_reset_default_R4: assert property (@(posedge wr_clk)
        rst |=> (empty_ofs == DEPTH_LOG2'(7) && full_ofs == DEPTH_LOG2'(7)));

    assert_rd_hold_R6: assert property (@(posedge rd_clk) disable iff (rst)
        (load_n || rd_en1_n || rd_en2_n) |=> $stable(rd_data));

    assert_noop_hold_R7: assert property (@(posedge wr_clk) disable iff (rst)
        (load_n || wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    assert_fifo_wr_excl_R8: assert property (@(posedge wr_clk) disable iff (rst)
        fifo_wr_req |-> load_n);

    assert_fifo_rd_excl_R8: assert property (@(posedge rd_clk) disable iff (rst)
        fifo_rd_req |-> load_n);

endmodule

bind flag_ofs_port flag_ofs_port_chk #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_chk (.*);

// File: tb/sim_flag_ofs_port.sv
module sim_flag_ofs_port;

    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DW = 9;
    localparam int PW = 15;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_n = 1'b1;
    logic          wr_en_n = 1'b1;
    logic          rd_en1_n = 1'b1;
    logic          rd_en2_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] rd_data;
    logic          fifo_wr_req;
    logic          fifo_rd_req;
    logic [PW-1:0] empty_ofs;
    logic [PW-1:0] full_ofs;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
    always #(RD_PERIOD / 2)  rd_clk = ~rd_clk;

    flag_ofs_port #(.DATA_W(DW), .DEPTH_LOG2(PW)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .load_n(load_n),
        .wr_en_n(wr_en_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
        .din(din), .rd_data(rd_data), .fifo_wr_req(fifo_wr_req),
        .fifo_rd_req(fifo_rd_req), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One offset write: strobe and enable low across one wr_clk edge.
    task automatic wr_ofs(input logic [DW-1:0] d);
        @(negedge wr_clk);
        load_n = 1'b0; wr_en_n = 1'b0; din = d;
        @(posedge wr_clk);
        @(negedge wr_clk);
        wr_en_n = 1'b1; load_n = 1'b1;
    endtask

    // One read-domain access with the given enables and strobe.
    task automatic rd_ofs(input logic ld, input logic e1, input logic e2);
        @(negedge rd_clk);
        load_n = ld; rd_en1_n = e1; rd_en2_n = e2;
        @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
        rst = 1'b0;
        chk("R4 empty_ofs default", 32'(empty_ofs), 32'd7);
        chk("R4 full_ofs default", 32'(full_ofs), 32'd7);
        chk("R4 rd_data cleared", 32'(rd_data), 32'd0);
        chk("R8 idle fifo_wr_req", 32'(fifo_wr_req), 32'd0);
    endtask

    task automatic t_prog_order;
        wr_ofs(9'h0A5);
        chk("R1 empty-low first", 32'(empty_ofs), 32'h0A5);
        chk("R1 full untouched", 32'(full_ofs), 32'd7);
        wr_ofs(9'h001);
        chk("R1 empty-high second", 32'(empty_ofs), 32'h2A5);
        wr_ofs(9'h033);
        chk("R1 full-low third", 32'(full_ofs), 32'h033);
        wr_ofs(9'h000);
        chk("R1 full-high fourth", 32'(full_ofs), 32'h033);
    endtask

    task automatic t_read_order;
        rd_ofs(1'b0, 1'b0, 1'b0);
        chk("R5 read empty-low", 32'(rd_data), 32'h0A5);
        rd_ofs(1'b0, 1'b0, 1'b0);
        chk("R5 read empty-high", 32'(rd_data), 32'h001);
        rd_ofs(1'b0, 1'b0, 1'b0);
        chk("R5 read full-low", 32'(rd_data), 32'h033);
        rd_ofs(1'b0, 1'b0, 1'b0);
        chk("R5 read full-high", 32'(rd_data), 32'h000);
        rd_ofs(1'b0, 1'b0, 1'b0);
        chk("R5 read wraps", 32'(rd_data), 32'h0A5);
    endtask

    task automatic t_wrap;
        wr_ofs(9'h010);
        chk("R2 fifth write hits empty-low", 32'(empty_ofs), 32'h210);
        chk("R2 full unchanged", 32'(full_ofs), 32'h033);
    endtask

    task automatic t_partial;
        // Offset write and write enable in the same cycle: no FIFO request.
        @(negedge wr_clk);
        load_n = 1'b0; wr_en_n = 1'b0; din = 9'h002;
        #1 chk("R8 no fifo write under strobe", 32'(fifo_wr_req), 32'd0);
        @(posedge wr_clk);
        @(negedge wr_clk);
        wr_en_n = 1'b1; load_n = 1'b1;
        chk("R3 empty-high written", 32'(empty_ofs), 32'h410);
        // Normal FIFO write with strobe high.
        @(negedge wr_clk);
        wr_en_n = 1'b0; din = 9'h1EE;
        #1 chk("R8 fifo write request", 32'(fifo_wr_req), 32'd1);
        @(posedge wr_clk);
        @(negedge wr_clk);
        wr_en_n = 1'b1;
        chk("R7 fifo write leaves empty", 32'(empty_ofs), 32'h410);
        chk("R7 fifo write leaves full", 32'(full_ofs), 32'h033);
        wr_ofs(9'h044);
        chk("R3 resumes at full-low", 32'(full_ofs), 32'h044);
        chk("R3 empty kept", 32'(empty_ofs), 32'h410);
    endtask

    task automatic t_noop;
        @(negedge wr_clk);
        load_n = 1'b0; wr_en_n = 1'b1; din = 9'h155;
        repeat (3) @(posedge wr_clk);
        @(negedge wr_clk);
        load_n = 1'b1;
        chk("R7 strobe without enable: empty", 32'(empty_ofs), 32'h410);
        chk("R7 strobe without enable: full", 32'(full_ofs), 32'h044);
        wr_ofs(9'h003);
        chk("R7 selector held, full-high next", 32'(full_ofs), 32'h644);
    endtask

    task automatic t_trunc;
        wr_ofs(9'h1FF);
        wr_ofs(9'h1FF);
        chk("R9 empty truncated to 15 bits", 32'(empty_ofs), 32'h7FFF);
        chk("R9 full kept", 32'(full_ofs), 32'h644);
    endtask

    task automatic t_rd_enables;
        rd_ofs(1'b0, 1'b0, 1'b1);
        chk("R6 second enable high holds", 32'(rd_data), 32'h0A5);
        rd_ofs(1'b0, 1'b1, 1'b0);
        chk("R6 first enable high holds", 32'(rd_data), 32'h0A5);
        @(negedge rd_clk);
        load_n = 1'b1; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        #1 chk("R8 fifo read request", 32'(fifo_rd_req), 32'd1);
        @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        chk("R6 strobe high holds", 32'(rd_data), 32'h0A5);
        rd_ofs(1'b0, 1'b0, 1'b0);
        chk("R6 selector held, empty-high next", 32'(rd_data), 32'h1FF);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (R1 sequence incomplete): actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_prog_order();
        t_read_order();
        t_wrap();
        t_partial();
        t_noop();
        t_trunc();
        t_rd_enables();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule